// File: doc/BRIEF.md
# Trigger Readout Stream Parser

This block takes the byte-serial readout record that one detector-interface board sends for a single trigger, checks its structure, and splits it into fields. The bytes arrive one per accepted transfer on a valid/ready input. The stream has a fixed-length global header, a run of chip sections (one per front-end chip in the readout chain), a global trailer and a 16-bit checksum. The block reports the decoded header once and each hit record as one wide word tagged with the chip it came from. It also reports the end of every chip section with its transfer status, and gives a single end-of-event summary.

The block is always ready after reset, so it never applies backpressure. Every result is a registered one-cycle pulse. The pulse is high in the clock cycle after the edge that accepted the last byte of the item it reports. When the structure is broken, the block flags a format error, drops the rest of the event and waits for the next event start byte. Parameters set the record limit per chip and the chip limit per event.

Top module: `evt_stream_parser`

## Requirements
- R1: A byte is taken only on a clock edge with inValid and inReady both high. inReady is low during reset and high from the first edge after reset. While reset is asserted, every pulse output is low.
- R2: Outside an event, any byte other than 0xB0 is ignored and produces no output. A 0xB0 starts an event.
- R3: The 22 bytes after 0xB0 form the global header, most significant byte first, in this order: board ID (8 bits), board trigger count (32), busy-trigger count (32), global trigger count (32), absolute BCID (48), board BCID (24). hdrValid pulses with these fields after the 22nd byte.
- R4: After the header, and after each chip section, byte 0xB4 opens a chip section and byte 0xA0 is the global trailer. Any other byte there raises fmtErr, and the block returns to waiting for 0xB0. The offending byte is consumed.
- R5: Inside a chip section, where a record would start, 0xA3 or 0xC3 closes the section. frameDone pulses with frameBad = 1 for 0xC3 and 0 for 0xA3. Any other byte starts a 20-byte hit record.
- R6: A hit record is a chip header byte, a 24-bit BCID and 128 data bits, most significant byte first. hitValid pulses after its 20th byte. hitChip (and frameChip) carry the zero-based index of the chip section within the event.
- R7: A chip section holds at most MAX_RECS records (default 128). A further record start byte raises fmtErr and returns the block to waiting for 0xB0.
- R8: An event holds at most MAX_CHIPS chip sections (default 48). A 0xB4 after MAX_CHIPS completed sections raises fmtErr and returns the block to waiting for 0xB0.
- R9: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, computed MSB-first over every byte from 0xB0 to 0xA0 inclusive. The two bytes after 0xA0 are the received CRC, high byte first. evtCrcOk is 1 exactly when they match.
- R10: After the second CRC byte, evtDone pulses with evtChips (the number of completed chip sections) and evtAnyBad (1 if any section in this event closed with 0xC3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Block accepts a byte |
| hdrValid | output | 1 | Global header decoded (pulse) |
| hdrBoardId | output | 8 | Board ID |
| hdrBoardTrig | output | 32 | Board trigger count |
| hdrBusyCnt | output | 32 | Busy-trigger count |
| hdrGlobTrig | output | 32 | Global trigger count |
| hdrAbsBcid | output | 48 | Absolute BCID |
| hdrBoardBcid | output | 24 | Board BCID |
| hitValid | output | 1 | Hit record complete (pulse) |
| hitChip | output | CHIP_W | Chip section index of the record |
| hitHeader | output | 8 | Chip header byte of the record |
| hitBcid | output | 24 | Record BCID |
| hitData | output | 128 | Record data |
| frameDone | output | 1 | Chip section closed (pulse) |
| frameChip | output | CHIP_W | Index of the closed section |
| frameBad | output | 1 | Section closed with the failure trailer |
| evtDone | output | 1 | Event complete (pulse) |
| evtCrcOk | output | 1 | Received CRC matched |
| evtChips | output | CHIP_W | Completed chip sections in the event |
| evtAnyBad | output | 1 | Some section in the event reported failure |
| fmtErr | output | 1 | Format error, event dropped (pulse) |

## Verification
The bench aims at the edges of each count. One case is a section with exactly 128 records followed by a 129th start byte; a design whose limit check is off by one would either emit a 129th hit or reject the 128th. Another is an event that reaches the chip limit and then sends one more 0xB4; a design that misses this wraps the chip index. Zero-chip events, empty chip sections, mixed 0xA3/0xC3 trailers and deliberately corrupted CRC bytes catch checksums that cover the wrong span or skip the trailer marker, and a sticky failure flag that leaks from one event into the next. Stray bytes before an event, bytes sent after a format error, and random gaps in inValid catch a parser that counts idle cycles or locks onto a byte that is not 0xB0.

// File: rtl/evt_parse_pkg.sv
package evt_parse_pkg;

  localparam logic [7:0] MK_EVT   = 8'hB0;
  localparam logic [7:0] MK_CHIP  = 8'hB4;
  localparam logic [7:0] MK_GOOD  = 8'hA3;
  localparam logic [7:0] MK_BAD   = 8'hC3;
  localparam logic [7:0] MK_TRAIL = 8'hA0;

  localparam int ID_W    = 8;
  localparam int CNT_W   = 32;
  localparam int ABS_W   = 48;
  localparam int BB_W    = 24;
  localparam int CHDR_W  = 8;
  localparam int BCID_W  = 24;
  localparam int DATA_W  = 128;

  localparam int HDR_BITS  = ID_W + 3 * CNT_W + ABS_W + BB_W;
  localparam int REC_BITS  = CHDR_W + BCID_W + DATA_W;
  localparam int HDR_BYTES = HDR_BITS / 8;
  localparam int REC_BYTES = REC_BITS / 8;
  localparam int BYTE_CW   = $clog2(HDR_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_GHDR, S_SEC, S_RSTART, S_RBODY, S_CRCH, S_CRCL
  } state_t;

  typedef struct packed {
    logic crcInit;
    logic crcUpd;
    logic shift;
    logic byteClr;
    logic byteInc;
    logic hdrLoad;
    logic hitLoad;
    logic recClr;
    logic chipClr;
    logic frameEnd;
    logic crcHiLoad;
    logic evtEnd;
    logic fmtErr;
  } strobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

endpackage

// File: rtl/evt_parse_ctrl.sv
module evt_parse_ctrl
  import evt_parse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       acc,
  input  logic [7:0] inData,
  input  logic       hdrLastByte,
  input  logic       recLastByte,
  input  logic       recFull,
  input  logic       chipFull,
  output strobe_t    strb
);

  state_t state, nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (acc) begin
      unique case (state)
        S_IDLE: begin
          if (inData == MK_EVT) begin
            strb.crcInit = 1'b1;
            strb.byteClr = 1'b1;
            strb.chipClr = 1'b1;
            nxt = S_GHDR;
          end
        end
        S_GHDR: begin
          strb.crcUpd  = 1'b1;
          strb.shift   = 1'b1;
          strb.byteInc = 1'b1;
          if (hdrLastByte) begin
            strb.hdrLoad = 1'b1;
            nxt = S_SEC;
          end
        end
        S_SEC: begin
          if (inData == MK_CHIP && !chipFull) begin
            strb.crcUpd  = 1'b1;
            strb.recClr  = 1'b1;
            strb.byteClr = 1'b1;
            nxt = S_RSTART;
          end else if (inData == MK_TRAIL) begin
            strb.crcUpd = 1'b1;
            nxt = S_CRCH;
          end else begin
            strb.fmtErr = 1'b1;
            nxt = S_IDLE;
          end
        end
        S_RSTART: begin
          if (inData == MK_GOOD || inData == MK_BAD) begin
            strb.crcUpd   = 1'b1;
            strb.frameEnd = 1'b1;
            nxt = S_SEC;
          end else if (recFull) begin
            strb.fmtErr = 1'b1;
            nxt = S_IDLE;
          end else begin
            strb.crcUpd  = 1'b1;
            strb.shift   = 1'b1;
            strb.byteInc = 1'b1;
            nxt = S_RBODY;
          end
        end
        S_RBODY: begin
          strb.crcUpd  = 1'b1;
          strb.shift   = 1'b1;
          strb.byteInc = 1'b1;
          if (recLastByte) begin
            strb.hitLoad = 1'b1;
            strb.byteClr = 1'b1;
            nxt = S_RSTART;
          end
        end
        S_CRCH: begin
          strb.crcHiLoad = 1'b1;
          nxt = S_CRCL;
        end
        S_CRCL: begin
          strb.evtEnd = 1'b1;
          nxt = S_IDLE;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  // R7
  rec_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitLoad |-> !recFull);

  // R8
  chip_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameEnd |-> !chipFull);

  // R4
  fmt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fmtErr |=> (state == S_IDLE));

endmodule

// File: rtl/evt_parse_dp.sv
module evt_parse_dp
  import evt_parse_pkg::*;
#(
  parameter int MAX_RECS  = 128,
  parameter int MAX_CHIPS = 48,
  parameter int REC_W     = $clog2(MAX_RECS + 1),
  parameter int CHIP_W    = $clog2(MAX_CHIPS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [7:0]          inData,
  output logic                hdrLastByte,
  output logic                recLastByte,
  output logic                recFull,
  output logic                chipFull,
  output logic                hdrValid,
  output logic [ID_W-1:0]     hdrBoardId,
  output logic [CNT_W-1:0]    hdrBoardTrig,
  output logic [CNT_W-1:0]    hdrBusyCnt,
  output logic [CNT_W-1:0]    hdrGlobTrig,
  output logic [ABS_W-1:0]    hdrAbsBcid,
  output logic [BB_W-1:0]     hdrBoardBcid,
  output logic                hitValid,
  output logic [CHIP_W-1:0]   hitChip,
  output logic [CHDR_W-1:0]   hitHeader,
  output logic [BCID_W-1:0]   hitBcid,
  output logic [DATA_W-1:0]   hitData,
  output logic                frameDone,
  output logic [CHIP_W-1:0]   frameChip,
  output logic                frameBad,
  output logic                evtDone,
  output logic                evtCrcOk,
  output logic [CHIP_W-1:0]   evtChips,
  output logic                evtAnyBad,
  output logic                fmtErr
);

  logic [HDR_BITS-1:0] sr, nextSr;
  logic [BYTE_CW-1:0]  byteCnt;
  logic [REC_W-1:0]    recCnt;
  logic [CHIP_W-1:0]   chipCnt;
  logic [15:0]         crc;
  logic [7:0]          crcHi;
  logic                anyBad;

  assign nextSr      = {sr[HDR_BITS-9:0], inData};
  assign hdrLastByte = (byteCnt == BYTE_CW'(HDR_BYTES - 1));
  assign recLastByte = (byteCnt == BYTE_CW'(REC_BYTES - 1));
  assign recFull     = (recCnt == REC_W'(MAX_RECS));
  assign chipFull    = (chipCnt == CHIP_W'(MAX_CHIPS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr <= '0; byteCnt <= '0; recCnt <= '0; chipCnt <= '0;
      crc <= 16'hFFFF; crcHi <= '0; anyBad <= 1'b0;
      hdrValid <= 1'b0; hdrBoardId <= '0; hdrBoardTrig <= '0; hdrBusyCnt <= '0;
      hdrGlobTrig <= '0; hdrAbsBcid <= '0; hdrBoardBcid <= '0;
      hitValid <= 1'b0; hitChip <= '0; hitHeader <= '0; hitBcid <= '0; hitData <= '0;
      frameDone <= 1'b0; frameChip <= '0; frameBad <= 1'b0;
      evtDone <= 1'b0; evtCrcOk <= 1'b0; evtChips <= '0; evtAnyBad <= 1'b0;
      fmtErr <= 1'b0;
    end else begin
      hdrValid  <= 1'b0;
      hitValid  <= 1'b0;
      frameDone <= 1'b0;
      evtDone   <= 1'b0;
      fmtErr    <= strb.fmtErr;

      if (strb.crcInit)     crc <= crcStep(16'hFFFF, inData);
      else if (strb.crcUpd) crc <= crcStep(crc, inData);

      if (strb.shift) sr <= nextSr;

      if (strb.byteClr)      byteCnt <= '0;
      else if (strb.byteInc) byteCnt <= byteCnt + 1'b1;

      if (strb.recClr)       recCnt <= '0;
      else if (strb.hitLoad) recCnt <= recCnt + 1'b1;

      if (strb.hdrLoad) begin
        hdrValid <= 1'b1;
        {hdrBoardId, hdrBoardTrig, hdrBusyCnt, hdrGlobTrig, hdrAbsBcid, hdrBoardBcid} <= nextSr;
      end

      if (strb.hitLoad) begin
        hitValid <= 1'b1;
        hitChip  <= chipCnt;
        {hitHeader, hitBcid, hitData} <= nextSr[REC_BITS-1:0];
      end

      if (strb.chipClr) begin
        chipCnt <= '0;
        anyBad  <= 1'b0;
      end else if (strb.frameEnd) begin
        chipCnt   <= chipCnt + 1'b1;
        frameDone <= 1'b1;
        frameChip <= chipCnt;
        frameBad  <= (inData == MK_BAD);
        if (inData == MK_BAD) anyBad <= 1'b1;
      end

      if (strb.crcHiLoad) crcHi <= inData;

      if (strb.evtEnd) begin
        evtDone   <= 1'b1;
        evtCrcOk  <= ({crcHi, inData} == crc);
        evtChips  <= chipCnt;
        evtAnyBad <= anyBad;
      end
    end
  end

  // R6
  hit_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (recCnt != '0));

  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |-> (!hitValid && !hdrValid && !frameDone));

  // R5
  frame_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (frameChip < CHIP_W'(MAX_CHIPS)));

endmodule

// File: rtl/evt_stream_parser.sv
module evt_stream_parser
  import evt_parse_pkg::*;
#(
  parameter int MAX_RECS  = 128,
  parameter int MAX_CHIPS = 48,
  localparam int REC_W    = $clog2(MAX_RECS + 1),
  localparam int CHIP_W   = $clog2(MAX_CHIPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [7:0]         inData,
  output logic               inReady,
  output logic               hdrValid,
  output logic [7:0]         hdrBoardId,
  output logic [31:0]        hdrBoardTrig,
  output logic [31:0]        hdrBusyCnt,
  output logic [31:0]        hdrGlobTrig,
  output logic [47:0]        hdrAbsBcid,
  output logic [23:0]        hdrBoardBcid,
  output logic               hitValid,
  output logic [CHIP_W-1:0]  hitChip,
  output logic [7:0]         hitHeader,
  output logic [23:0]        hitBcid,
  output logic [127:0]       hitData,
  output logic               frameDone,
  output logic [CHIP_W-1:0]  frameChip,
  output logic               frameBad,
  output logic               evtDone,
  output logic               evtCrcOk,
  output logic [CHIP_W-1:0]  evtChips,
  output logic               evtAnyBad,
  output logic               fmtErr
);

  strobe_t strb;
  logic hdrLastByte, recLastByte, recFull, chipFull;
  logic acc;

  always_ff @(posedge clk) begin
    if (!rstN) inReady <= 1'b0;
    else       inReady <= 1'b1;
  end

  assign acc = inValid & inReady;

  evt_parse_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .acc(acc), .inData(inData),
    .hdrLastByte(hdrLastByte), .recLastByte(recLastByte),
    .recFull(recFull), .chipFull(chipFull), .strb(strb)
  );

  evt_parse_dp #(
    .MAX_RECS(MAX_RECS), .MAX_CHIPS(MAX_CHIPS), .REC_W(REC_W), .CHIP_W(CHIP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .hdrLastByte(hdrLastByte), .recLastByte(recLastByte),
    .recFull(recFull), .chipFull(chipFull),
    .hdrValid(hdrValid), .hdrBoardId(hdrBoardId), .hdrBoardTrig(hdrBoardTrig),
    .hdrBusyCnt(hdrBusyCnt), .hdrGlobTrig(hdrGlobTrig), .hdrAbsBcid(hdrAbsBcid),
    .hdrBoardBcid(hdrBoardBcid),
    .hitValid(hitValid), .hitChip(hitChip), .hitHeader(hitHeader),
    .hitBcid(hitBcid), .hitData(hitData),
    .frameDone(frameDone), .frameChip(frameChip), .frameBad(frameBad),
    .evtDone(evtDone), .evtCrcOk(evtCrcOk), .evtChips(evtChips),
    .evtAnyBad(evtAnyBad), .fmtErr(fmtErr)
  );

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> (!evtDone && !hitValid && !hdrValid));

endmodule

// File: tb/tb_evt_stream_parser.sv
module tb_evt_stream_parser;

  localparam int MAXR = 128;
  localparam int MAXC = 48;
  localparam int CW   = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, hdrValid, hitValid, frameDone, frameBad, evtDone, evtCrcOk, evtAnyBad, fmtErr;
  logic [7:0] hdrBoardId, hitHeader;
  logic [31:0] hdrBoardTrig, hdrBusyCnt, hdrGlobTrig;
  logic [47:0] hdrAbsBcid;
  logic [23:0] hdrBoardBcid, hitBcid;
  logic [127:0] hitData;
  logic [CW-1:0] hitChip, frameChip, evtChips;

  always #10 clk = ~clk;

  evt_stream_parser #(.MAX_RECS(MAXR), .MAX_CHIPS(MAXC)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .hdrValid(hdrValid), .hdrBoardId(hdrBoardId), .hdrBoardTrig(hdrBoardTrig),
    .hdrBusyCnt(hdrBusyCnt), .hdrGlobTrig(hdrGlobTrig), .hdrAbsBcid(hdrAbsBcid),
    .hdrBoardBcid(hdrBoardBcid), .hitValid(hitValid), .hitChip(hitChip),
    .hitHeader(hitHeader), .hitBcid(hitBcid), .hitData(hitData),
    .frameDone(frameDone), .frameChip(frameChip), .frameBad(frameBad),
    .evtDone(evtDone), .evtCrcOk(evtCrcOk), .evtChips(evtChips),
    .evtAnyBad(evtAnyBad), .fmtErr(fmtErr)
  );

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  int gotFmt = 0;
  int expFmt = 0;
  bit monOn = 1'b0;

  logic [7:0] q[$];
  logic [175:0] expHdr[$];
  logic [CW+160-1:0] expHit[$];
  logic [CW:0] expFrame[$];
  logic [CW+1:0] expEvt[$];
  logic [15:0] bCrc;

  task automatic chk(input bit ok, input string req, input string what);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic put(input logic [7:0] b);
    q.push_back(b);
    bCrc = refCrc(bCrc, b);
  endtask

  task automatic putN(input logic [175:0] v, input int nBytes);
    for (int k = nBytes - 1; k >= 0; k--) put(v[k*8 +: 8]);
  endtask

  task automatic addHeader();
    logic [175:0] h;
    h = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    bCrc = 16'hFFFF;
    put(8'hB0);
    putN(h, 22);
    expHdr.push_back(h);
  endtask

  task automatic addRecord(input int chip);
    logic [159:0] r;
    logic [7:0] hb;
    do hb = 8'($urandom); while (hb == 8'hA3 || hb == 8'hC3);
    r = {hb, 24'($urandom), $urandom, $urandom, $urandom, $urandom};
    putN({16'h0, r}, 20);
    expHit.push_back({CW'(chip), r});
  endtask

  task automatic addEvent(input int nChips, input int nRecs, input bit allowBad, input bit badCrc);
    bit anyBad;
    bit bad;
    int nr;
    logic [15:0] c;
    anyBad = 1'b0;
    addHeader();
    for (int ch = 0; ch < nChips; ch++) begin
      put(8'hB4);
      nr = (nRecs < 0) ? int'($urandom % 6) : nRecs;
      for (int r = 0; r < nr; r++) addRecord(ch);
      bad = allowBad && ($urandom % 3 == 0);
      anyBad |= bad;
      put(bad ? 8'hC3 : 8'hA3);
      expFrame.push_back({CW'(ch), bad});
    end
    put(8'hA0);
    c = bCrc ^ (badCrc ? 16'h0100 : 16'h0000);
    q.push_back(c[15:8]);
    q.push_back(c[7:0]);
    expEvt.push_back({!badCrc, CW'(nChips), anyBad});
  endtask

  task automatic feed();
    while (q.size() != 0) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        inValid = 1'b0;
        inData  = 8'hB0;
      end else begin
        inValid = 1'b1;
        inData  = q.pop_front();
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(expHdr.size() == 0, req, $sformatf("header queue left %0d, expected 0", expHdr.size()));
    chk(expHit.size() == 0, req, $sformatf("hit queue left %0d, expected 0", expHit.size()));
    chk(expFrame.size() == 0, req, $sformatf("frame queue left %0d, expected 0", expFrame.size()));
    chk(expEvt.size() == 0, req, $sformatf("event queue left %0d, expected 0", expEvt.size()));
    chk(gotFmt == expFmt, req, $sformatf("format errors %0d, expected %0d", gotFmt, expFmt));
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (hdrValid) begin
        logic [175:0] g;
        g = {hdrBoardId, hdrBoardTrig, hdrBusyCnt, hdrGlobTrig, hdrAbsBcid, hdrBoardBcid};
        if (expHdr.size() == 0) chk(1'b0, "R3", "unexpected header pulse, expected none");
        else begin
          logic [175:0] e;
          e = expHdr.pop_front();
          chk(g == e, "R3", $sformatf("header %h, expected %h", g, e));
        end
      end
      if (hitValid) begin
        logic [CW+160-1:0] g;
        g = {hitChip, hitHeader, hitBcid, hitData};
        if (expHit.size() == 0) chk(1'b0, "R6", "unexpected hit pulse, expected none");
        else begin
          logic [CW+160-1:0] e;
          e = expHit.pop_front();
          chk(g == e, "R6", $sformatf("hit %h, expected %h", g, e));
        end
      end
      if (frameDone) begin
        if (expFrame.size() == 0) chk(1'b0, "R5", "unexpected frame pulse, expected none");
        else begin
          logic [CW:0] e;
          e = expFrame.pop_front();
          chk({frameChip, frameBad} == e, "R5",
              $sformatf("frame %h, expected %h", {frameChip, frameBad}, e));
        end
      end
      if (evtDone) begin
        if (expEvt.size() == 0) chk(1'b0, "R10", "unexpected event pulse, expected none");
        else begin
          logic [CW+1:0] e;
          e = expEvt.pop_front();
          chk(evtCrcOk == e[CW+1], "R9", $sformatf("crcOk %0b, expected %0b", evtCrcOk, e[CW+1]));
          chk({evtChips, evtAnyBad} == e[CW:0], "R10",
              $sformatf("event %h, expected %h", {evtChips, evtAnyBad}, e[CW:0]));
        end
      end
      if (fmtErr) gotFmt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(inReady == 1'b0, "R1", $sformatf("inReady %0b in reset, expected 0", inReady));
    chk({hdrValid, hitValid, frameDone, evtDone, fmtErr} == 5'b0, "R1",
        $sformatf("pulses %b in reset, expected 0", {hdrValid, hitValid, frameDone, evtDone, fmtErr}));
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1", $sformatf("inReady %0b after reset, expected 1", inReady));
    monOn = 1'b1;

    // R2: stray bytes before an event are ignored
    q.push_back(8'h12); q.push_back(8'hA0); q.push_back(8'hB4); q.push_back(8'hC3);
    addEvent(1, 2, 1'b0, 1'b0);
    feed();
    drained("R2");

    // R10: zero-chip event
    addEvent(0, 0, 1'b0, 1'b0);
    feed();
    drained("R10");

    // R5: empty sections, both trailer kinds
    addEvent(3, 0, 1'b1, 1'b0);
    feed();
    drained("R5");

    // R9: random events, some with corrupted CRC
    for (int n = 0; n < 20; n++) begin
      addEvent(int'($urandom % 5), -1, 1'b1, ($urandom % 4 == 0));
      feed();
    end
    drained("R9");

    // R7: 128 records accepted, 129th start rejected
    addHeader();
    put(8'hB4);
    for (int r = 0; r < MAXR; r++) addRecord(0);
    for (int k = 0; k < 20; k++) q.push_back(8'h11);
    expFmt++;
    feed();
    drained("R7");

    // R4: unexpected byte where a section or trailer is required
    addHeader();
    put(8'hB4);
    addRecord(0);
    put(8'hA3);
    expFrame.push_back({CW'(0), 1'b0});
    q.push_back(8'h55);
    q.push_back(8'hA0);
    q.push_back(8'h00);
    expFmt++;
    feed();
    drained("R4");

    // R8: chip limit reached, one more section rejected
    addHeader();
    for (int ch = 0; ch < MAXC; ch++) begin
      put(8'hB4);
      put(8'hA3);
      expFrame.push_back({CW'(ch), 1'b0});
    end
    q.push_back(8'hB4);
    q.push_back(8'hA3);
    expFmt++;
    feed();
    drained("R8");

    // R8: a full-size event at the chip limit still completes
    addEvent(MAXC, 0, 1'b1, 1'b0);
    feed();
    drained("R8");

    // R2: clean event after errors
    addEvent(2, 3, 1'b1, 1'b0);
    feed();
    drained("R2");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule